// File: doc/BRIEF.md
# Panel Switch Scanner

The scanner reads a front panel in short bursts, one burst per interrupt tick. Ticks arrive about every 1.9 ms. Each tick first opens a status window. During this window the status gate is driven low and all scan lines stay high, and the transport and tempo status inputs are captured. The window is followed by a column phase in which one scan line is driven low and the step rows and function rows behind that column are read. After about 600 µs of activity the block goes idle until the next tick.

The driven column advances by one on each tick, so the full 4-column matrix is covered every fourth tick. Each switch is reported only when two successive reads of its column agree. Step-LED drives for the active column are set as soon as a step is seen closed, or when the supplied LED pattern requests it. They are held until the next tick clears them, so at most one column group of LEDs is lit per tick. Row and status inputs pass through two synchronizing flops before use, and the scan lines and the status gate come straight from flops.

Top module: `panel_scanner`

## Requirements
- R1: After reset, all scan lines are high, the status gate is high, and status_o, step_o, func_o and led_o are all zero. The first column scanned is column 0.
- R2: A tick seen while idle opens a status window of STATUS_CYC cycles. The status gate is low and all scan lines are high for exactly those cycles.
- R3: status_o captures the synchronized status_i at the close of each status window. It holds that value until the next window closes.
- R4: After the status window, only scan line c (scan_no[c]=0) is low, for SCAN_CYC cycles, and then all lines return high. The value of c is 0,1,2,3,0,... on successive ticks.
- R5: A row input reads 0 when the switch at that row in the driven column is closed. A closed step row r in column c is reported at step_o[c*STEP_ROWS+r], and a closed function row f at func_o[c*FUNC_ROWS+f].
- R6: A column's reported switch state changes only when two consecutive reads of that column agree. A single read that differs leaves the reported state unchanged.
- R7: While column c is driven, led_o[c*STEP_ROWS+r] is set if step row r is seen closed or if led_pattern_i at that index is 1. Set bits stay set until the next tick clears all of led_o. No other bit of led_o is set.
- R8: A tick that arrives during the status window or the column phase is ignored. Window timing and column order are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Scan interrupt tick, one-cycle pulse |
| status_i | input | N_STAT | Tempo clock, start/stop and tap status lines |
| step_row_ni | input | STEP_ROWS | Step switch rows, low when closed |
| func_row_ni | input | FUNC_ROWS | Function switch rows, low when closed |
| led_pattern_i | input | N_COLS*STEP_ROWS | Requested step-LED pattern |
| scan_no | output | N_COLS | Scan lines, active low |
| status_gate_no | output | 1 | Status gate enable, active low |
| status_o | output | N_STAT | Status captured this tick |
| step_o | output | N_COLS*STEP_ROWS | Debounced step switch states, 1 = closed |
| func_o | output | N_COLS*FUNC_ROWS | Debounced function switch states, 1 = closed |
| led_o | output | N_COLS*STEP_ROWS | Latched step-LED drives |

## Verification
If the column index is corrupted, a scan line other than the expected one goes low after the status window of that same tick. The stored switch state then lands in the wrong step_o bits one full pass later. A wrong phase counter shows up as a shifted gate edge or a shifted scan edge within the same tick. A stale previous-read store in the debouncer makes a switch report after one read instead of two, or after three reads instead of two, which is visible four ticks later. A missed LED clear leaves bits of a previous column lit during the next status window.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_STAT = 2'd1,
    PH_SCAN = 2'd2
  } phase_e;
endpackage

// File: rtl/scan_sync.sv
module scan_sync #(
  parameter int W = 1,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= {W{RST_VAL}};
      s2_q <= {W{RST_VAL}};
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/scan_timer.sv
module scan_timer
  import scan_pkg::*;
#(
  parameter int N_COLS     = 4,
  parameter int STATUS_CYC = 7500,
  parameter int SCAN_CYC   = 22500,
  localparam int COL_W = (N_COLS > 1) ? $clog2(N_COLS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output phase_e           phase_o,
  output logic [COL_W-1:0] col_o,
  output logic             start_o,
  output logic             stat_done_o,
  output logic             scan_done_o,
  output logic [N_COLS-1:0] scan_no,
  output logic             status_gate_no
);
  localparam int MAXC  = (STATUS_CYC > SCAN_CYC) ? STATUS_CYC : SCAN_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] STAT_LAST = CNT_W'(STATUS_CYC - 1);
  localparam logic [CNT_W-1:0] SCAN_LAST = CNT_W'(SCAN_CYC - 1);
  localparam logic [COL_W-1:0] COL_LAST  = COL_W'(N_COLS - 1);

  phase_e             phase_q, phase_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [COL_W-1:0]   col_q, col_d;
  logic [N_COLS-1:0]  scan_q;
  logic               gate_q;

  always_comb begin
    phase_d     = phase_q;
    cnt_d       = cnt_q;
    col_d       = col_q;
    start_o     = 1'b0;
    stat_done_o = 1'b0;
    scan_done_o = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (tick_i) begin
        phase_d = PH_STAT;
        cnt_d   = '0;
        start_o = 1'b1;
      end
      PH_STAT: if (cnt_q == STAT_LAST) begin
        phase_d     = PH_SCAN;
        cnt_d       = '0;
        stat_done_o = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
      PH_SCAN: if (cnt_q == SCAN_LAST) begin
        phase_d     = PH_IDLE;
        cnt_d       = '0;
        scan_done_o = 1'b1;
        col_d       = (col_q == COL_LAST) ? '0 : col_q + 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  // outputs registered from next state so they change with the phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      col_q   <= '0;
      scan_q  <= '1;
      gate_q  <= 1'b1;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      col_q   <= col_d;
      scan_q  <= (phase_d == PH_SCAN) ? ~(N_COLS'(1) << col_d) : '1;
      gate_q  <= (phase_d != PH_STAT);
    end
  end

  assign phase_o        = phase_q;
  assign col_o          = col_q;
  assign scan_no        = scan_q;
  assign status_gate_no = gate_q;

  a_r4_single_low_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~scan_no) <= 1);

  a_r2_gate_lines_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_gate_no |-> (&scan_no));

  a_r8_busy_tick_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_IDLE && tick_i && !stat_done_o && !scan_done_o)
      |=> (phase_q == $past(phase_q) && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/scan_debounce.sv
module scan_debounce #(
  parameter int N_COLS = 4,
  parameter int ROW_W  = 6,
  localparam int COL_W = (N_COLS > 1) ? $clog2(N_COLS) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [COL_W-1:0]        col_i,
  input  logic [ROW_W-1:0]        raw_i,
  output logic [N_COLS*ROW_W-1:0] state_o
);
  for (genvar c = 0; c < N_COLS; c++) begin : g_col
    logic [ROW_W-1:0] prev_q, stab_q;
    logic             hit;
    assign hit = valid_i && (col_i == COL_W'(c));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= '0;
        stab_q <= '0;
      end else if (hit) begin
        prev_q <= raw_i;
        if (raw_i == prev_q) stab_q <= raw_i;
      end
    end

    assign state_o[c*ROW_W +: ROW_W] = stab_q;
  end

  a_r6_hold_between_reads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(state_o));
endmodule

// File: rtl/panel_scanner.sv
module panel_scanner
  import scan_pkg::*;
#(
  parameter int N_COLS     = 4,
  parameter int STEP_ROWS  = 4,
  parameter int FUNC_ROWS  = 2,
  parameter int N_STAT     = 3,
  parameter int STATUS_CYC = 7500,
  parameter int SCAN_CYC   = 22500,
  localparam int N_STEPS = N_COLS * STEP_ROWS,
  localparam int N_FUNC  = N_COLS * FUNC_ROWS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic [N_STAT-1:0]    status_i,
  input  logic [STEP_ROWS-1:0] step_row_ni,
  input  logic [FUNC_ROWS-1:0] func_row_ni,
  input  logic [N_STEPS-1:0]   led_pattern_i,
  output logic [N_COLS-1:0]    scan_no,
  output logic                 status_gate_no,
  output logic [N_STAT-1:0]    status_o,
  output logic [N_STEPS-1:0]   step_o,
  output logic [N_FUNC-1:0]    func_o,
  output logic [N_STEPS-1:0]   led_o
);
  localparam int ROW_W = STEP_ROWS + FUNC_ROWS;
  localparam int COL_W = (N_COLS > 1) ? $clog2(N_COLS) : 1;

  phase_e             phase;
  logic [COL_W-1:0]   col;
  logic               start, stat_done, scan_done;
  logic [STEP_ROWS-1:0] step_s;
  logic [FUNC_ROWS-1:0] func_s;
  logic [N_STAT-1:0]  status_s;
  logic [N_STAT-1:0]  status_q;
  logic [N_STEPS-1:0] led_q;
  logic [N_COLS*ROW_W-1:0] state;
  logic [ROW_W-1:0]   raw;

  scan_timer #(
    .N_COLS(N_COLS), .STATUS_CYC(STATUS_CYC), .SCAN_CYC(SCAN_CYC)
  ) u_timer (
    .clk_i, .rst_ni, .tick_i,
    .phase_o(phase), .col_o(col), .start_o(start),
    .stat_done_o(stat_done), .scan_done_o(scan_done),
    .scan_no, .status_gate_no
  );

  scan_sync #(.W(STEP_ROWS), .RST_VAL(1'b1)) u_sync_step (
    .clk_i, .rst_ni, .d_i(step_row_ni), .q_o(step_s));
  scan_sync #(.W(FUNC_ROWS), .RST_VAL(1'b1)) u_sync_func (
    .clk_i, .rst_ni, .d_i(func_row_ni), .q_o(func_s));
  scan_sync #(.W(N_STAT), .RST_VAL(1'b0)) u_sync_stat (
    .clk_i, .rst_ni, .d_i(status_i), .q_o(status_s));

  assign raw = {~func_s, ~step_s};

  scan_debounce #(.N_COLS(N_COLS), .ROW_W(ROW_W)) u_deb (
    .clk_i, .rst_ni, .valid_i(scan_done), .col_i(col),
    .raw_i(raw), .state_o(state));

  for (genvar c = 0; c < N_COLS; c++) begin : g_map
    assign step_o[c*STEP_ROWS +: STEP_ROWS] = state[c*ROW_W +: STEP_ROWS];
    assign func_o[c*FUNC_ROWS +: FUNC_ROWS] = state[c*ROW_W+STEP_ROWS +: FUNC_ROWS];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else if (stat_done) status_q <= status_s;
  end

  // LED drive: sticky within a tick, cleared when the next tick starts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      led_q <= '0;
    end else if (start) begin
      led_q <= '0;
    end else if (phase == PH_SCAN) begin
      for (int r = 0; r < STEP_ROWS; r++) begin
        if (led_pattern_i[int'(col)*STEP_ROWS + r] || !step_s[r])
          led_q[int'(col)*STEP_ROWS + r] <= 1'b1;
      end
    end
  end

  assign status_o = status_q;
  assign led_o    = led_q;

  a_r3_status_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_done |=> $stable(status_o));

  a_r7_led_clear_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_gate_no |-> (led_o == '0));
endmodule

// File: tb/tb_panel_scanner.sv
`timescale 1ns/1ps
module tb_panel_scanner;
  localparam int S = 4;
  localparam int C = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic [2:0]  status_i = '0;
  logic [3:0]  step_row_ni;
  logic [1:0]  func_row_ni;
  logic [15:0] led_pattern_i = '0;
  logic [3:0]  scan_no;
  logic        status_gate_no;
  logic [2:0]  status_o;
  logic [15:0] step_o;
  logic [7:0]  func_o;
  logic [15:0] led_o;

  logic [15:0] press_step = '0;
  logic [7:0]  press_func = '0;
  int errors = 0, checks = 0, exp_col = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  panel_scanner #(.STATUS_CYC(S), .SCAN_CYC(C)) dut (
    .clk_i, .rst_ni, .tick_i, .status_i, .step_row_ni, .func_row_ni,
    .led_pattern_i, .scan_no, .status_gate_no, .status_o, .step_o,
    .func_o, .led_o);

  // switch matrix model: closed contact pulls the row low when its line is low
  always_comb begin
    step_row_ni = '1;
    func_row_ni = '1;
    for (int c = 0; c < 4; c++) begin
      if (!scan_no[c]) begin
        for (int r = 0; r < 4; r++) if (press_step[c*4+r]) step_row_ni[r] = 1'b0;
        for (int f = 0; f < 2; f++) if (press_func[c*2+f]) func_row_ni[f] = 1'b0;
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one full tick; extra=1 adds ticks inside the status and column phases
  task automatic run_tick(bit extra);
    logic [2:0] st = status_i;
    logic [3:0] low = ~(4'b1 << exp_col);
    @(negedge clk_i) tick_i = 1'b1;
    for (int i = 0; i <= S + C + 1; i++) begin
      @(negedge clk_i);
      tick_i = extra && (i == 1 || i == S + 1);
      if (i == 0) begin
        check("R2 gate low at start", status_gate_no, 0);
        check("R2 lines high in window", scan_no, 4'hF);
        check("R7 leds cleared at tick", led_o, 0);
      end
      if (i == S - 1) check("R2 gate still low", status_gate_no, 0);
      if (i == S) begin
        check("R2 gate closes", status_gate_no, 1);
        check("R4 column line low", scan_no, low);
        check("R3 status captured", status_o, st);
      end
      if (i == S + C - 1) check("R4 line held", scan_no, low);
      if (i == S + C) check("R4 lines released", scan_no, 4'hF);
    end
    tick_i = 1'b0;
    exp_col = (exp_col + 1) % 4;
  endtask

  task automatic goto_col(int c);
    while (exp_col != c) run_tick(0);
  endtask

  task automatic t_reset();
    check("R1 scan lines", scan_no, 4'hF);
    check("R1 gate", status_gate_no, 1);
    check("R1 status", status_o, 0);
    check("R1 steps", step_o, 0);
    check("R1 func", func_o, 0);
    check("R1 leds", led_o, 0);
  endtask

  task automatic t_status();
    status_i = 3'b101;
    repeat (3) @(negedge clk_i);
    run_tick(0);
    status_i = 3'b010;
    repeat (3) @(negedge clk_i);
    check("R3 status held after window", status_o, 3'b101);
    run_tick(0);
    check("R3 status next tick", status_o, 3'b010);
  endtask

  task automatic t_debounce();
    goto_col(1);
    press_step[5] = 1'b1;
    run_tick(0);
    check("R6 one read not enough", step_o, 0);
    run_tick(0); run_tick(0);
    run_tick(1); // R8 busy ticks on column 0
    check("R8 column order kept", exp_col, 1);
    run_tick(0);
    check("R6 two reads agree", step_o, 16'h0020);
    press_step[5] = 1'b0;
    goto_col(1);
    run_tick(0);
    check("R6 single open read ignored", step_o, 16'h0020);
    press_step[5] = 1'b1;
    goto_col(1);
    run_tick(0);
    check("R6 state kept after glitch", step_o, 16'h0020);
  endtask

  task automatic t_mapping();
    press_func[6]  = 1'b1;
    press_step[14] = 1'b1;
    goto_col(3); run_tick(0);
    goto_col(3); run_tick(0);
    check("R5 function row map", func_o, 8'h40);
    check("R5 step row map", step_o, 16'h4020);
    press_step = '0;
    press_func = '0;
    goto_col(0); // clear stored states with two passes
    repeat (8) run_tick(0);
    check("R5 all released", step_o, 0);
    check("R5 func released", func_o, 0);
  endtask

  task automatic t_led();
    led_pattern_i = 16'h0201;
    goto_col(2);
    run_tick(0);
    check("R7 pattern in active column only", led_o, 16'h0200);
    goto_col(0);
    press_step[2] = 1'b1;
    run_tick(0);
    check("R7 pressed and pattern lit", led_o, 16'h0005);
    press_step[2] = 1'b0;
    repeat (5) @(negedge clk_i);
    check("R7 leds held until tick", led_o, 16'h0005);
    led_pattern_i = '0;
    run_tick(0);
    check("R7 no leds without cause", led_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_status();
    t_debounce();
    t_mapping();
    t_led();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule